// File: doc/BRIEF.md
# Block Transfer Sequencer

This block walks a block of words between a character buffer and memory without software touching each word. It holds a 15-bit word count and a 15-bit memory address. Every time the buffer reports a full (input) or empty (output) word, the sequencer issues one memory request at the current address and holds the host in a stall until memory acknowledges. It then steps the address up by one and the count down by one.

Software arms it in three steps. An enable command latches the transfer direction. An optional high-count command sets the upper six count bits. A 24-bit parallel write supplies the lower nine count bits and the start address. The operation ends when the count runs out. In the input direction it also ends on an end-of-record mark. Either way the sequencer disables itself.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: After reset the sequencer is idle: `active_o`, `mem_req_o` and `stall_o` are 0, and `count_o` and `mem_addr_o` are 0.
- R2: An enable command (`en_cmd_i`) in the idle or armed state sets `active_o` on the next cycle. It also latches the direction from `dir_in_i` (1 = input, which writes memory; 0 = output, which reads memory), and `mem_we_o` shows that direction during a transfer. The enable command leaves the count and the address unchanged.
- R3: A high-count load (`hi_ld_i`) writes `hi_data_i[5:0]` into `count_o[14:9]` and leaves `count_o[8:0]` unchanged.
- R4: A parallel load (`par_ld_i`) writes `par_data_i[8:0]` into `count_o[8:0]` and `par_data_i[23:9]` into `mem_addr_o`.
- R5: A parallel load made while armed that leaves a zero count clears `active_o` on the next cycle and issues no memory request.
- R6: When `buf_ready_i` is high while running, `stall_o` rises in that same cycle. `mem_req_o` rises on the next cycle with `mem_addr_o` at the current address. Both stay high, with the address stable, until `mem_ack_i`.
- R7: In the cycle after an acknowledge, `mem_addr_o` has increased by one modulo 2^15, `count_o` has decreased by one, and the request and stall are low.
- R8: If an acknowledge brings the count to zero, `active_o` is 0 on the next cycle, in both directions.
- R9: In the input direction, `eor_i` while running clears `active_o` on the next cycle. `eor_i` during a pending transfer ends the operation right after that transfer's acknowledge. In the output direction `eor_i` has no effect.
- R10: Load and enable commands are ignored while running or transferring. `buf_ready_i` is ignored when the sequencer is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_cmd_i | input | 1 | Enable command pulse |
| dir_in_i | input | 1 | Direction for enable: 1 input, 0 output |
| hi_ld_i | input | 1 | High count load strobe |
| hi_data_i | input | 6 | High count bits |
| par_ld_i | input | 1 | Parallel load strobe |
| par_data_i | input | 24 | [8:0] low count, [23:9] address |
| buf_ready_i | input | 1 | Buffer word ready |
| eor_i | input | 1 | End-of-record mark |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write (input direction) |
| mem_addr_o | output | 15 | Current address |
| mem_ack_i | input | 1 | Memory acknowledge |
| stall_o | output | 1 | Host stall |
| active_o | output | 1 | Sequencer enabled |
| count_o | output | 15 | Remaining word count |

## Verification
Assertions check on every cycle that a request holds with a stable address until it is acknowledged. They also check that each acknowledge steps the address and the count by exactly one, that a zero count never coexists with the running state, and that a zero-count load or an input end-of-record drops `active_o`. The bench scenarios are needed to show the split count assembled from two loads, address wrap-around, the end-of-record that arrives mid-transfer, the output direction ignoring that mark, and commands being ignored while a block is moving.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RUN,
    ST_XFER
  } xfer_state_e;
endpackage

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int CNT_W = 15,
  parameter int HI_W  = 6,
  localparam int LO_W = CNT_W - HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_ld_i,
  input  logic [HI_W-1:0]  hi_i,
  input  logic             lo_ld_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ld_zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      if (hi_ld_i) cnt_q[CNT_W-1:LO_W] <= hi_i;
      if (lo_ld_i) cnt_q[LO_W-1:0]     <= lo_i;
    end
  end

  // zero check on the value a low load is about to create
  assign hi_next   = hi_ld_i ? hi_i : cnt_q[CNT_W-1:LO_W];
  assign ld_zero_o = (hi_next == '0) && (lo_i == '0);
  assign last_o    = (cnt_q == CNT_W'(1));
  assign cnt_o     = cnt_q;

  a_r7_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
  a_r3_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_ld_i && !lo_ld_i && !dec_i) |=> $stable(cnt_q[LO_W-1:0]));
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
    else if (ld_i)   addr_q <= ld_val_i;
  end

  assign addr_o = addr_q;

  a_r7_addr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> addr_q == $past(addr_q) + 1'b1);
  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(addr_q));
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import blk_xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_cmd_i,
  input  logic dir_in_i,
  input  logic par_ld_i,
  input  logic ld_zero_i,
  input  logic last_i,
  input  logic buf_ready_i,
  input  logic eor_i,
  input  logic ack_i,
  output logic load_ok_o,
  output logic step_o,
  output logic req_o,
  output logic stall_o,
  output logic active_o,
  output logic dir_in_o
);
  xfer_state_e st_q, st_d;
  logic        dir_q;
  logic        eor_pend_q;
  logic        eor_in;

  assign eor_in    = dir_q && eor_i;
  assign load_ok_o = (st_q == ST_IDLE) || (st_q == ST_ARMED);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (en_cmd_i) st_d = ST_ARMED;
      ST_ARMED: if (par_ld_i) st_d = ld_zero_i ? ST_IDLE : ST_RUN;
      ST_RUN: begin
        if (eor_in)           st_d = ST_IDLE;
        else if (buf_ready_i) st_d = ST_XFER;
      end
      ST_XFER:
        if (ack_i) st_d = (last_i || eor_pend_q || eor_in) ? ST_IDLE : ST_RUN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      dir_q      <= 1'b0;
      eor_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (en_cmd_i && load_ok_o) dir_q <= dir_in_i;
      if (st_q != ST_XFER || ack_i) eor_pend_q <= 1'b0;
      else if (eor_in)              eor_pend_q <= 1'b1;
    end
  end

  assign req_o    = (st_q == ST_XFER);
  assign step_o   = (st_q == ST_XFER) && ack_i;
  assign stall_o  = (st_q == ST_XFER) || ((st_q == ST_RUN) && buf_ready_i && !eor_in);
  assign active_o = (st_q != ST_IDLE);
  assign dir_in_o = dir_q;

  a_r6_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  a_r6_stall_then_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && stall_o) |=> req_o);
  a_r5_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && par_ld_i && ld_zero_i) |=> !active_o);
  a_r8_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last_i) |=> !active_o);
  a_r9_eor_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && eor_in) |=> !active_o && !req_o);
  a_r10_dir_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ok_o |=> $stable(dir_q));
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl #(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 15,
  parameter int HI_W   = 6,
  localparam int LO_W  = CNT_W - HI_W,
  localparam int PAR_W = LO_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_cmd_i,
  input  logic              dir_in_i,
  input  logic              hi_ld_i,
  input  logic [HI_W-1:0]   hi_data_i,
  input  logic              par_ld_i,
  input  logic [PAR_W-1:0]  par_data_i,
  input  logic              buf_ready_i,
  input  logic              eor_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  output logic              stall_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  count_o
);
  logic load_ok, step, ld_zero, last, dir_in;
  logic hi_ld_ok, par_ld_ok;

  assign hi_ld_ok  = hi_ld_i && load_ok;
  assign par_ld_ok = par_ld_i && load_ok;

  xfer_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_cmd_i    (en_cmd_i),
    .dir_in_i    (dir_in_i),
    .par_ld_i    (par_ld_ok),
    .ld_zero_i   (ld_zero),
    .last_i      (last),
    .buf_ready_i (buf_ready_i),
    .eor_i       (eor_i),
    .ack_i       (mem_ack_i),
    .load_ok_o   (load_ok),
    .step_o      (step),
    .req_o       (mem_req_o),
    .stall_o     (stall_o),
    .active_o    (active_o),
    .dir_in_o    (dir_in)
  );

  xfer_count #(.CNT_W(CNT_W), .HI_W(HI_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_ld_i   (hi_ld_ok),
    .hi_i      (hi_data_i),
    .lo_ld_i   (par_ld_ok),
    .lo_i      (par_data_i[LO_W-1:0]),
    .dec_i     (step),
    .cnt_o     (count_o),
    .ld_zero_o (ld_zero),
    .last_o    (last)
  );

  xfer_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (par_ld_ok),
    .ld_val_i (par_data_i[PAR_W-1:LO_W]),
    .inc_i    (step),
    .addr_o   (mem_addr_o)
  );

  assign mem_we_o = dir_in;

  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o) && $stable(count_o));
  a_r8_run_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> count_o != '0);
  a_r10_loads_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(count_o));
endmodule

// File: tb/blk_xfer_ctrl_tb.sv
module blk_xfer_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_cmd = 0, dir_in = 0, hi_ld = 0, par_ld = 0;
  logic [5:0]  hi_data = '0;
  logic [23:0] par_data = '0;
  logic        buf_ready = 0, eor = 0, ack = 0;
  logic        mem_req, mem_we, stall, active;
  logic [14:0] mem_addr, count;

  int checks = 0, errors = 0;
  logic [14:0] exp_addr, exp_cnt;
  logic        exp_dir;

  always #2 clk = ~clk;

  blk_xfer_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_cmd_i(en_cmd), .dir_in_i(dir_in),
    .hi_ld_i(hi_ld), .hi_data_i(hi_data), .par_ld_i(par_ld), .par_data_i(par_data),
    .buf_ready_i(buf_ready), .eor_i(eor), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_ack_i(ack), .stall_o(stall), .active_o(active),
    .count_o(count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [23:0] pack_par(logic [14:0] a, logic [8:0] lo);
    return {a, lo};
  endfunction

  task automatic do_enable(logic d);
    en_cmd = 1; dir_in = d; tick(); en_cmd = 0;
    exp_dir = d;
  endtask

  task automatic do_hi(logic [5:0] v);
    hi_ld = 1; hi_data = v; tick(); hi_ld = 0;
    exp_cnt[14:9] = v;
  endtask

  task automatic do_par(logic [14:0] a, logic [8:0] lo);
    par_ld = 1; par_data = pack_par(a, lo); tick(); par_ld = 0;
    exp_cnt[8:0] = lo; exp_addr = a;
  endtask

  task automatic do_xfer(int dly, bit eor_mid);
    buf_ready = 1; #1;
    check("R6 stall same cycle", stall, 1);
    tick(); buf_ready = 0;
    check("R6 req raised", mem_req, 1);
    check("R6 req address", mem_addr, exp_addr);
    check("R2 write flag", mem_we, exp_dir);
    for (int i = 0; i < dly; i++) begin
      eor = eor_mid && (i == 0);
      tick(); eor = 0;
      check("R6 req held", {stall, mem_req}, 2'b11);
      check("R6 address stable", mem_addr, exp_addr);
    end
    ack = 1; tick(); ack = 0;
    exp_addr = exp_addr + 1'b1;
    exp_cnt  = exp_cnt - 1'b1;
    check("R7 address step", mem_addr, exp_addr);
    check("R7 count step", count, exp_cnt);
    check("R7 req released", {mem_req, stall}, 0);
    if (exp_cnt == 0) check("R8 count end", active, 0);
    else if (eor_mid && exp_dir && dly > 0) check("R9 eor mid transfer", active, 0);
    else check("R9 still running", active, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_addr = '0; exp_cnt = '0; exp_dir = 0;
    #5; rst_n = 1; tick();
    // R1
    check("R1 reset idle", {active, mem_req, stall}, 0);
    check("R1 reset count", count, 0);
    check("R1 reset address", mem_addr, 0);

    // R10: ready in idle ignored
    buf_ready = 1; tick(); buf_ready = 0; tick();
    check("R10 ready idle ignored", mem_req, 0);

    // R2/R3/R4 combined count, ready while armed ignored
    do_enable(0);
    check("R2 enable active", active, 1);
    check("R2 enable keeps count", count, 0);
    buf_ready = 1; tick(); buf_ready = 0; tick();
    check("R10 ready armed ignored", mem_req, 0);
    do_hi(6'h3F);
    check("R3 high bits", count, 15'h7E00);
    hi_ld = 1; hi_data = 6'h2A; par_ld = 0; tick(); hi_ld = 0;
    exp_cnt[14:9] = 6'h2A;
    check("R3 low bits kept", count, 15'h5400);

    // R4 load, output direction, wrap 7FFE
    do_hi(6'h00);
    do_par(15'h7FFE, 9'd3);
    check("R4 low count", count, 3);
    check("R4 address", mem_addr, 15'h7FFE);
    do_xfer(0, 0);
    // R9: eor ignored in output
    eor = 1; tick(); eor = 0;
    check("R9 output ignores eor", active, 1);
    // R10: loads/enable ignored while running
    par_ld = 1; par_data = pack_par(15'h1234, 9'd77); hi_ld = 1; hi_data = 6'h11;
    en_cmd = 1; dir_in = 1; tick(); par_ld = 0; hi_ld = 0; en_cmd = 0;
    check("R10 count unchanged", count, exp_cnt);
    check("R10 address unchanged", mem_addr, exp_addr);
    do_xfer(2, 1);
    do_xfer(1, 0);
    check("R7 address wrapped", mem_addr, 15'h0001);
    check("R8 output done", active, 0);

    // R5 zero-count load
    do_enable(1); do_hi(0); do_par(15'h0100, 9'd0);
    check("R5 zero load ends", active, 0);
    check("R5 no request", mem_req, 0);

    // R9 input with eor while running
    do_enable(1); do_hi(6'h01); do_par(15'h0040, 9'd5);
    check("R3 split count", count, 15'd517);
    do_xfer(1, 0);
    do_xfer(0, 0);
    eor = 1; tick(); eor = 0;
    check("R9 eor ends input", active, 0);
    check("R9 count retained", count, 15'd515);

    // R9 eor during transfer, input
    do_enable(1); do_hi(0); do_par(15'h0200, 9'd9);
    do_xfer(2, 1);
    check("R9 mid-transfer end count", count, 8);

    // random runs
    for (int r = 0; r < 8; r++) begin
      logic d;
      logic [14:0] a;
      logic [8:0] n;
      d = 1'($urandom_range(0, 1));
      a = 15'($urandom());
      n = 9'($urandom_range(1, 6));
      do_enable(d); do_hi(0); do_par(a, n);
      while (exp_cnt != 0) do_xfer($urandom_range(0, 3), 0);
      check("R8 random run done", active, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule